// File: doc/BRIEF.md
# PCI Interrupt Pin Router

This block collects the INTx level interrupts of every device on a PCI bus and presents them as sixteen level interrupt lines for a legacy interrupt controller. Each device slot contributes four pins, INTA to INTD. A fixed rotation that depends on the slot number folds those pins onto four shared lines, called PIRQ 0 to 3. Four byte-wide routing registers then steer each shared line onto one of the sixteen outputs, or switch it off.

The routing registers sit in a small byte-wide configuration space. Software writes them to change the routing and reads them back to check it. When a routing register is written, the block emits a one-cycle notification so that neighbouring logic can learn of the new mapping. The block stores the mapping as a grid with one bit for each PIRQ and output pair. The outputs are therefore an OR over registered state, and a new routing takes effect on the very next clock edge.

Top module: `pirq_router`

## Requirements
- R1: Device pin n of slot s (n = 0 for INTA up to 3 for INTD, input bit s*4+n of `dev_int_i`) drives PIRQ line (n + s + 3) mod 4, that is (n + s - 1) mod 4.
- R2: A PIRQ line is active while at least one device pin that rotates onto it is high.
- R3: Routing registers for PIRQ 0, 1, 2 and 3 sit at byte offsets 0x60, 0x61, 0x62 and 0x63. A write stores `cfg_wdata`. `cfg_rdata` returns the byte at `cfg_addr` one clock later. Any other offset reads as 0x00, and writes to other offsets change nothing.
- R4: A routing value of 16 or more turns its PIRQ off, and that PIRQ then drives no output.
- R5: `irq_o[i]` equals the OR of all active PIRQ lines whose routing value is i. It is registered, and it follows a pin change one clock later.
- R6: After a write to a routing register, the outputs reflect the new routing at the next clock edge. The output that the PIRQ left drops unless another routed PIRQ still holds it.
- R7: `route_chg_o` is high for exactly one clock after every write to offsets 0x60 to 0x63, including a write of an unchanged value. It stays low after writes to other offsets.
- R8: Synchronous reset sets all four routing registers to 0x80, clears the level grid, and drives `irq_o` and `route_chg_o` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| dev_int_i | input | 128 | Device pin levels, bit slot*4+pin |
| cfg_we | input | 1 | Configuration byte write strobe |
| cfg_addr | input | 8 | Configuration byte offset |
| cfg_wdata | input | 8 | Configuration write data |
| cfg_rdata | output | 8 | Registered read data for `cfg_addr` |
| irq_o | output | 16 | Level interrupts to the controller |
| route_chg_o | output | 1 | One-cycle routing-change notification |

## Verification
Every result of this block is due exactly one rising edge after its cause:
- an output level after a pin change;
- a new mapping after a routing write;
- the notification pulse after that write;
- read data after an offset is presented.

The bench changes inputs on the falling edge and samples the outputs on the following falling edge. Each check therefore lands after that single register stage. For the notification, the bench samples on that falling edge and again one edge later, to confirm that the pulse lasts exactly one clock. The expected interrupt lines come from a bench model of the rotation and the routing. The bench compares the whole 16-bit vector against that model for directed and pseudo-random patterns.

// File: rtl/pirq_pkg.sv
package pirq_pkg;
  localparam int PIRQ_N   = 4;
  localparam int PIRQ_W   = $clog2(PIRQ_N);
  localparam int PINS_PER = 4;

  // Shared line for a pin of a slot: (pin + slot - 1) mod 4
  function automatic logic [PIRQ_W-1:0] rot_line(input int slot, input int pin);
    return PIRQ_W'((pin + slot + PIRQ_N - 1) % PIRQ_N);
  endfunction
endpackage

// File: rtl/pirq_swizzle.sv
module pirq_swizzle
  import pirq_pkg::*;
#(
  parameter int NUM_SLOTS = 32
) (
  input  logic [NUM_SLOTS*PINS_PER-1:0] dev_int_i,
  output logic [PIRQ_N-1:0]             pirq_lvl_o
);
  // Fold every slot's pins onto the shared lines (R1, R2)
  always_comb begin
    pirq_lvl_o = '0;
    for (int s = 0; s < NUM_SLOTS; s++) begin
      for (int n = 0; n < PINS_PER; n++) begin
        pirq_lvl_o[rot_line(s, n)] = pirq_lvl_o[rot_line(s, n)] | dev_int_i[s*PINS_PER+n];
      end
    end
  end
endmodule

// File: rtl/pirq_route_regs.sv
module pirq_route_regs
  import pirq_pkg::*;
#(
  parameter int AW        = 8,
  parameter int DW        = 8,
  parameter int BASE      = 'h60,
  parameter int RESET_VAL = 'h80
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     cfg_we,
  input  logic [AW-1:0]            cfg_addr,
  input  logic [DW-1:0]            cfg_wdata,
  output logic [PIRQ_N-1:0][DW-1:0] route_nx_o,
  output logic [DW-1:0]            cfg_rdata,
  output logic                     route_chg_o
);
  localparam logic [AW-1:0] LO = AW'(BASE);
  localparam logic [AW-1:0] HI = AW'(BASE + PIRQ_N - 1);

  logic [PIRQ_N-1:0][DW-1:0] route_q;
  logic                      hit;
  logic [PIRQ_W-1:0]         idx;
  logic                      wr_hit;

  assign hit    = (cfg_addr >= LO) && (cfg_addr <= HI);
  assign idx    = PIRQ_W'(cfg_addr - LO);
  assign wr_hit = cfg_we && hit;

  // Post-write routing, forwarded so the level grid sees it in the same edge
  always_comb begin
    route_nx_o = route_q;
    if (wr_hit) route_nx_o[idx] = cfg_wdata;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      route_q     <= {PIRQ_N{DW'(RESET_VAL)}};
      route_chg_o <= 1'b0;
      cfg_rdata   <= '0;
    end else begin
      route_q     <= route_nx_o;
      route_chg_o <= wr_hit;
      cfg_rdata   <= hit ? route_q[idx] : '0;
    end
  end

  assert_reset_routes_R8: assert property (@(posedge clk)
    rst |=> (route_q == {PIRQ_N{DW'(RESET_VAL)}}) && !route_chg_o);

  assert_pulse_from_write_R7: assert property (@(posedge clk) disable iff (rst)
    route_chg_o |-> $past(cfg_we) && ($past(cfg_addr) >= LO) && ($past(cfg_addr) <= HI));

  assert_other_write_ignored_R3: assert property (@(posedge clk) disable iff (rst)
    (cfg_we && !hit) |=> $stable(route_q) && !route_chg_o);
endmodule

// File: rtl/pirq_level_map.sv
module pirq_level_map
  import pirq_pkg::*;
#(
  parameter int NUM_IRQS = 16,
  parameter int DW       = 8
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic [PIRQ_N-1:0][DW-1:0] route_i,
  input  logic [PIRQ_N-1:0]         pirq_lvl_i,
  output logic [NUM_IRQS-1:0]       irq_o
);
  localparam int VEC_W = NUM_IRQS * PIRQ_N;

  logic [VEC_W-1:0] vec_q, vec_d;

  // Grid bit irq*4+pirq: PIRQ active and routed to that interrupt (R4, R5)
  always_comb begin
    for (int i = 0; i < NUM_IRQS; i++) begin
      for (int p = 0; p < PIRQ_N; p++) begin
        vec_d[i*PIRQ_N+p] = pirq_lvl_i[p] && (route_i[p] == DW'(i));
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) vec_q <= '0;
    else     vec_q <= vec_d;
  end

  for (genvar i = 0; i < NUM_IRQS; i++) begin : g_out
    assign irq_o[i] = |vec_q[i*PIRQ_N +: PIRQ_N];
  end

  for (genvar p = 0; p < PIRQ_N; p++) begin : g_col
    logic [NUM_IRQS-1:0] col;
    for (genvar i = 0; i < NUM_IRQS; i++) begin : g_bit
      assign col[i] = vec_q[i*PIRQ_N+p];
    end

    assert_one_line_per_pirq_R5: assert property (@(posedge clk) disable iff (rst)
      $onehot0(col));

    assert_disabled_silent_R4: assert property (@(posedge clk) disable iff (rst)
      ($past(route_i[p]) >= DW'(NUM_IRQS)) |-> (col == '0));
  end

  assert_reset_quiet_R8: assert property (@(posedge clk)
    rst |=> (irq_o == '0));
endmodule

// File: rtl/pirq_router.sv
module pirq_router
  import pirq_pkg::*;
#(
  parameter int NUM_SLOTS  = 32,
  parameter int NUM_IRQS   = 16,
  parameter int AW         = 8,
  parameter int DW         = 8,
  parameter int ROUTE_BASE = 'h60,
  parameter int ROUTE_RST  = 'h80
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic [NUM_SLOTS*PINS_PER-1:0] dev_int_i,
  input  logic                          cfg_we,
  input  logic [AW-1:0]                 cfg_addr,
  input  logic [DW-1:0]                 cfg_wdata,
  output logic [DW-1:0]                 cfg_rdata,
  output logic [NUM_IRQS-1:0]           irq_o,
  output logic                          route_chg_o
);
  logic [PIRQ_N-1:0]         pirq_lvl;
  logic [PIRQ_N-1:0][DW-1:0] route_nx;

  pirq_swizzle #(.NUM_SLOTS(NUM_SLOTS)) u_swz (
    .dev_int_i (dev_int_i),
    .pirq_lvl_o(pirq_lvl)
  );

  pirq_route_regs #(
    .AW(AW), .DW(DW), .BASE(ROUTE_BASE), .RESET_VAL(ROUTE_RST)
  ) u_regs (
    .clk        (clk),
    .rst        (rst),
    .cfg_we     (cfg_we),
    .cfg_addr   (cfg_addr),
    .cfg_wdata  (cfg_wdata),
    .route_nx_o (route_nx),
    .cfg_rdata  (cfg_rdata),
    .route_chg_o(route_chg_o)
  );

  pirq_level_map #(.NUM_IRQS(NUM_IRQS), .DW(DW)) u_map (
    .clk       (clk),
    .rst       (rst),
    .route_i   (route_nx),
    .pirq_lvl_i(pirq_lvl),
    .irq_o     (irq_o)
  );
endmodule

// File: tb/pirq_router_tb.sv
`timescale 1ns/1ps
module pirq_router_tb;
  logic         clk = 1'b0;
  logic         rst;
  logic [127:0] dev;
  logic         we;
  logic [7:0]   addr, wdata;
  logic [7:0]   rdata;
  logic [15:0]  irq;
  logic         chg;

  int checks = 0;
  int errors = 0;
  logic [7:0] rt [4];
  logic [31:0] seed = 32'h1234_5678;

  always #2.5 clk = ~clk;

  pirq_router u_dut (
    .clk(clk), .rst(rst), .dev_int_i(dev), .cfg_we(we), .cfg_addr(addr),
    .cfg_wdata(wdata), .cfg_rdata(rdata), .irq_o(irq), .route_chg_o(chg)
  );

  function automatic logic [15:0] model(input logic [127:0] d);
    logic [3:0]  lv = '0;
    logic [15:0] e  = '0;
    for (int s = 0; s < 32; s++)
      for (int n = 0; n < 4; n++)
        if (d[s*4+n]) lv[(n + s + 3) % 4] = 1'b1;
    for (int p = 0; p < 4; p++)
      if (lv[p] && rt[p] < 8'd16) e[rt[p][3:0]] = 1'b1;
    return e;
  endfunction

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %h exp %h", req, got, exp);
    end
  endtask

  function automatic logic [31:0] rnd();
    seed = seed * 32'd1103515245 + 32'd12345;
    return seed;
  endfunction

  // Drive pins on a falling edge; outputs due after one rising edge
  task automatic set_pins(input logic [127:0] d, input string req);
    dev = d;
    @(negedge clk);
    check(req, {16'h0, irq}, {16'h0, model(dev)});
  endtask

  task automatic cfg_write(input logic [7:0] a, input logic [7:0] v, input string req);
    logic route = (a >= 8'h60) && (a <= 8'h63);
    we = 1'b1; addr = a; wdata = v;
    if (route) rt[a[1:0]] = v;
    @(negedge clk);
    we = 1'b0;
    check({req, " R7 pulse"}, {31'h0, chg}, {31'h0, route});
    check({req, " R6 irq"}, {16'h0, irq}, {16'h0, model(dev)});
    @(negedge clk);
    check({req, " R7 one-cycle"}, {31'h0, chg}, 32'h0);
  endtask

  task automatic cfg_read(input logic [7:0] a, input logic [7:0] exp, input string req);
    addr = a;
    @(negedge clk);
    check(req, {24'h0, rdata}, {24'h0, exp});
  endtask

  task automatic t_reset();
    check("R8 irq", {16'h0, irq}, 32'h0);
    check("R8 chg", {31'h0, chg}, 32'h0);
    for (int p = 0; p < 4; p++) cfg_read(8'h60 + 8'(p), 8'h80, "R8 R3 reset route");
  endtask

  task automatic t_disabled();
    set_pins({128{1'b1}}, "R4 reset routes off");
  endtask

  task automatic t_swizzle();
    dev = '0;
    cfg_write(8'h60, 8'd5, "R3 write pirq0");
    cfg_read(8'h60, 8'd5, "R3 readback");
    set_pins(128'h10, "R1 slot1 INTA to pirq0 irq5");
    check("R1 irq5", {31'h0, irq[5]}, 32'h1);
    cfg_write(8'h63, 8'd9, "R3 write pirq3");
    set_pins(128'h1, "R1 slot0 INTA to pirq3 irq9");
    check("R1 irq9", {16'h0, irq}, 32'h0200);
    set_pins(128'h400, "R1 slot2 INTC to pirq3");
    check("R2 irq9 from slot2", {16'h0, irq}, 32'h0200);
    set_pins(128'h401, "R2 two pins one pirq");
    set_pins(128'h400, "R2 one pin left");
    check("R2 still high", {31'h0, irq[9]}, 32'h1);
  endtask

  task automatic t_shared_irq();
    cfg_write(8'h61, 8'd5, "R5 pirq1 to irq5");
    set_pins(128'h30, "R5 pirq0 and pirq1 on irq5");
    set_pins(128'h20, "R5 pirq1 holds irq5");
    check("R5 irq5 held", {31'h0, irq[5]}, 32'h1);
    set_pins(128'h0, "R5 all low");
    check("R5 irq5 low", {16'h0, irq}, 32'h0);
  endtask

  task automatic t_reroute();
    set_pins(128'h10, "R6 pirq0 high");
    cfg_write(8'h60, 8'd7, "R6 move pirq0 to irq7");
    check("R6 irq7 only", {16'h0, irq}, 32'h0080);
    cfg_write(8'h60, 8'd7, "R7 same value write");
    cfg_write(8'h60, 8'd16, "R4 value 16 off");
    check("R4 off at 16", {16'h0, irq}, 32'h0);
    cfg_write(8'h60, 8'hFF, "R4 value FF off");
    check("R4 off at FF", {16'h0, irq}, 32'h0);
    cfg_write(8'h60, 8'd15, "R4 value 15 on");
    check("R4 on at 15", {16'h0, irq}, 32'h8000);
  endtask

  task automatic t_other_offset();
    cfg_write(8'h64, 8'd3, "R3 write 0x64");
    cfg_write(8'h5F, 8'd3, "R3 write 0x5F");
    cfg_read(8'h64, 8'h00, "R3 read 0x64");
    cfg_read(8'h60, 8'd15, "R3 pirq0 unchanged");
    check("R3 outputs unchanged", {16'h0, irq}, 32'h8000);
  endtask

  task automatic t_sweep();
    for (int k = 0; k < 60; k++) begin
      logic [31:0] r = rnd();
      if (r[0]) cfg_write(8'h60 + 8'(r[2:1]), r[7] ? 8'h80 : 8'(r[11:8]), "R5 sweep route");
      set_pins({rnd() & rnd(), rnd() & rnd(), rnd() & rnd(), rnd() & rnd()}, "R5 sweep");
    end
  endtask

  initial begin
    rst = 1'b1; dev = '0; we = 1'b0; addr = '0; wdata = '0;
    for (int p = 0; p < 4; p++) rt[p] = 8'h80;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_disabled();
    t_swizzle();
    t_shared_irq();
    t_reroute();
    t_other_offset();
    t_sweep();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog got timeout exp finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule